// File: doc/BRIEF.md
# Dual-Ramp Two-Channel PWM Generator

This block is a 12-bit up-counting waveform generator with two pulse-width modulated outputs, A and B. Each output has its own pair of compare values: a "set" value at which it turns active and a "clear" value at which it turns inactive. The time before the set match is that channel's dead time, and the time between set and clear is its on-time. Placing a channel's set and clear values where you want them fixes both.

The counter runs in one of two ramp styles. In one-ramp style, a single count from zero up to the B-clear value covers both channels. In two-ramp style, the cycle is split into two counts. The first count runs from zero to the A-clear value and serves channel A. The second count runs from zero to the B-clear value and serves channel B.

A small write-only register port loads the four compare values into buffers. The buffers reach the live compares only at a cycle boundary. The same port sets the ramp style, the run bit, and the per-channel output enables and idle levels. The run bit may only change while the ready flag is high. An overflow strobe marks the end of each full cycle, and a phase flag shows when the second ramp is counting.

Top module: `dual_ramp_pwm`

## Requirements
- R1: In one-ramp style (control bit 1 = 0), the counter counts 0, 1, ... up to B-clear and then restarts at 0. One full cycle lasts B-clear + 1 clocks.
- R2: In two-ramp style (control bit 1 = 1), the counter counts 0 to A-clear, then 0 to B-clear, for a cycle of (A-clear + 1) + (B-clear + 1) clocks. `ramp_b` is high for exactly the B-clear + 1 clocks of the second ramp. It is never high in one-ramp style.
- R3: A channel output goes to 1 in the clock after the count equals its set value and returns to 0 in the clock after the count equals its clear value. Each cycle therefore has clear − set active clocks. In two-ramp style, A compares act only during the first ramp and B compares only during the second.
- R4: When a channel's set and clear values are equal, clear takes priority and the output stays 0 for the whole cycle (parameter `CLEAR_WINS` = 1, the default).
- R5: In one-ramp style with A-set < A-clear ≤ B-set < B-clear, `pwm_a` and `pwm_b` are never high in the same clock.
- R6: `oe_a` and `oe_b` follow the channel enable bits. An output whose enable bit is 0 stays 0 at all times.
- R7: While the run bit is 0, each enabled output shows its idle level, the counter is held at zero from the next clock on, and no overflow strobe is produced after that clock.
- R8: `en_ready` is 1 after reset. It drops to 0 for exactly one clock after a control write that changes the run bit. A control write that arrives while `en_ready` is 0 is ignored entirely.
- R9: Compare writes go to buffers. While running, the buffers reach the live compares and the ramp style only at the end of a full cycle, so the cycle in progress completes with the old values. While stopped, the live compares follow the buffers every clock.
- R10: `cyc_ovf` is a one-clock pulse in the clock after the counter holds the final count of a full cycle. The counter reads 0 whenever the pulse is high.
- R11: Register map on `wr_addr`:
  - 0 = A-set, 1 = A-clear, 2 = B-set, 3 = B-clear, each taking the full `wr_data`.
  - 4 = control: bit 0 is the run bit, bit 1 is the ramp style.
  - 5 = output setup: bit 0 enables A, bit 1 enables B, bit 2 is A's idle level, bit 3 is B's idle level.
  - Any other address is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W | Write data |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| oe_a | output | 1 | Channel A drive enable |
| oe_b | output | 1 | Channel B drive enable |
| en_ready | output | 1 | High when the run bit may be changed |
| cyc_ovf | output | 1 | End-of-cycle strobe |
| ramp_b | output | 1 | High while the second ramp counts |

## Verification
Setup writes (output enables and idle levels) show at the pins one clock after the write edge. The ready flag is low in exactly the clock after a run-bit change. Channel levels move one clock after the count meets a compare, and the overflow strobe rises one clock after the final count.

Inputs change on falling edges and outputs are sampled on falling edges, so each sample falls inside the clock in which the result is due. Waveform results are taken over whole windows running from one overflow strobe to the next. Period, active clocks and second-ramp clocks are counted in those windows, so an on-time that is off by one clock, or a window that is cut short, shows up as a count mismatch. For the buffering rule, a compare is rewritten in the clock right after a strobe, and both the interrupted cycle and the one after it are measured.

// File: rtl/pwm2_pkg.sv
`timescale 1ns/1ps
package pwm2_pkg;
   localparam int NUM_CH = 2;
   localparam int CH_A   = 0;
   localparam int CH_B   = 1;
   localparam int REG_AW = 3;

   typedef enum logic {
      RAMP_ONE = 1'b0,
      RAMP_TWO = 1'b1
   } ramp_mode_e;

   typedef enum logic [REG_AW-1:0] {
      RA_A_SET  = 3'd0,
      RA_A_CLR  = 3'd1,
      RA_B_SET  = 3'd2,
      RA_B_CLR  = 3'd3,
      RA_CTRL   = 3'd4,
      RA_OUTCFG = 3'd5
   } reg_addr_e;

   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_MODE_BIT = 1;
   localparam int CFG_EN_LSB    = 0;
   localparam int CFG_DFLT_LSB  = 2;
endpackage

// File: rtl/pwm2_regs.sv
`timescale 1ns/1ps
module pwm2_regs import pwm2_pkg::*; #(
   parameter int CNT_W = 12
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [REG_AW-1:0]              wr_addr,
   input  logic [CNT_W-1:0]               wr_data,
   input  logic                           cyc_end,
   output logic [NUM_CH-1:0][CNT_W-1:0]   act_set,
   output logic [NUM_CH-1:0][CNT_W-1:0]   act_clr,
   output logic                           two_ramp,
   output logic                           run_q,
   output logic                           rdy_q,
   output logic [NUM_CH-1:0]              ch_en,
   output logic [NUM_CH-1:0]              ch_dflt
);
   logic ctrl_wr;
   logic cfg_wr;
   logic run_flip;
   logic load_act;
   logic mode_buf;
   logic mode_next;

   // run bit and style are only writable while ready is up
   assign ctrl_wr   = wr_en && (wr_addr == RA_CTRL) && rdy_q;
   assign cfg_wr    = wr_en && (wr_addr == RA_OUTCFG);
   assign run_flip  = ctrl_wr && (wr_data[CTRL_RUN_BIT] != run_q);
   // live copies refresh every clock while stopped, else at cycle end
   assign load_act  = !run_q || cyc_end;
   assign mode_next = ctrl_wr ? wr_data[CTRL_MODE_BIT] : mode_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         rdy_q    <= 1'b1;
         mode_buf <= RAMP_ONE;
         two_ramp <= RAMP_ONE;
         ch_en    <= '0;
         ch_dflt  <= '0;
      end else begin
         rdy_q <= !run_flip;
         if (ctrl_wr) begin
            run_q    <= wr_data[CTRL_RUN_BIT];
            mode_buf <= wr_data[CTRL_MODE_BIT];
         end
         if (cfg_wr) begin
            ch_en   <= wr_data[CFG_EN_LSB +: NUM_CH];
            ch_dflt <= wr_data[CFG_DFLT_LSB +: NUM_CH];
         end
         if (load_act) two_ramp <= mode_next;
      end
   end

   // one buffer/live pair per channel: set at 2*ch, clear at 2*ch+1
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
      localparam logic [REG_AW-1:0] SET_ADDR = REG_AW'(2 * ch);
      localparam logic [REG_AW-1:0] CLR_ADDR = REG_AW'(2 * ch + 1);
      logic [CNT_W-1:0] buf_set, buf_clr, live_set, live_clr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            buf_set  <= '0;
            buf_clr  <= '0;
            live_set <= '0;
            live_clr <= '0;
         end else begin
            if (wr_en && wr_addr == SET_ADDR) buf_set <= wr_data;
            if (wr_en && wr_addr == CLR_ADDR) buf_clr <= wr_data;
            if (load_act) begin
               live_set <= buf_set;
               live_clr <= buf_clr;
            end
         end
      end

      assign act_set[ch] = live_set;
      assign act_clr[ch] = live_clr;
   end
endmodule

// File: rtl/pwm2_ramp.sv
`timescale 1ns/1ps
module pwm2_ramp #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             two_ramp,
   input  logic [CNT_W-1:0] top_a,
   input  logic [CNT_W-1:0] top_b,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ph_b,
   output logic             cyc_end
);
   logic             in_first;
   logic [CNT_W-1:0] top_now;
   logic             at_top;

   // first ramp of two-ramp style ends at A-clear, every other ramp at B-clear
   assign in_first = two_ramp && !ph_b;
   assign top_now  = in_first ? top_a : top_b;
   assign at_top   = (cnt_q == top_now);
   assign cyc_end  = run && at_top && !in_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ph_b  <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         ph_b  <= 1'b0;
      end else if (at_top) begin
         cnt_q <= '0;
         ph_b  <= in_first;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/pwm2_chan.sv
`timescale 1ns/1ps
module pwm2_chan #(
   parameter int CNT_W      = 12,
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             in_phase,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_set,
   input  logic [CNT_W-1:0] cmp_clr,
   input  logic             en,
   input  logic             dflt,
   output logic             pin,
   output logic             oe
);
   logic hit_set;
   logic hit_clr;
   logic wave;

   assign hit_set = in_phase && (cnt == cmp_set);
   assign hit_clr = in_phase && (cnt == cmp_clr);

   if (CLEAR_WINS) begin : g_clr_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       wave <= 1'b0;
         else if (!run)    wave <= 1'b0;
         else if (hit_clr) wave <= 1'b0;
         else if (hit_set) wave <= 1'b1;
      end
   end else begin : g_set_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       wave <= 1'b0;
         else if (!run)    wave <= 1'b0;
         else if (hit_set) wave <= 1'b1;
         else if (hit_clr) wave <= 1'b0;
      end
   end

   assign pin = en && (run ? wave : dflt);
   assign oe  = en;
endmodule

// File: rtl/dual_ramp_pwm.sv
`timescale 1ns/1ps
module dual_ramp_pwm import pwm2_pkg::*; #(
   parameter int CNT_W      = 12,
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic              pwm_a,
   output logic              pwm_b,
   output logic              oe_a,
   output logic              oe_b,
   output logic              en_ready,
   output logic              cyc_ovf,
   output logic              ramp_b
);
   localparam int CFG_BITS = CFG_DFLT_LSB + NUM_CH;

   if (CNT_W < CFG_BITS || CNT_W > 24) begin : g_bad_width
      $error("dual_ramp_pwm: CNT_W must lie between %0d and 24", CFG_BITS);
   end

   logic [NUM_CH-1:0][CNT_W-1:0] act_set;
   logic [NUM_CH-1:0][CNT_W-1:0] act_clr;
   logic                         two_ramp;
   logic                         run_q;
   logic                         rdy_q;
   logic [NUM_CH-1:0]            ch_en;
   logic [NUM_CH-1:0]            ch_dflt;
   logic [CNT_W-1:0]             cnt_q;
   logic                         ph_b;
   logic                         cyc_end;
   logic [NUM_CH-1:0]            pins;
   logic [NUM_CH-1:0]            oes;

   pwm2_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cyc_end(cyc_end), .act_set(act_set),
      .act_clr(act_clr), .two_ramp(two_ramp), .run_q(run_q),
      .rdy_q(rdy_q), .ch_en(ch_en), .ch_dflt(ch_dflt)
   );

   pwm2_ramp #(.CNT_W(CNT_W)) u_ramp (
      .clk(clk), .rst_n(rst_n), .run(run_q), .two_ramp(two_ramp),
      .top_a(act_clr[CH_A]), .top_b(act_clr[CH_B]),
      .cnt_q(cnt_q), .ph_b(ph_b), .cyc_end(cyc_end)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      localparam logic OWN_PH = (ch == CH_B);
      logic in_phase;
      assign in_phase = (two_ramp == RAMP_ONE) || (ph_b == OWN_PH);

      pwm2_chan #(.CNT_W(CNT_W), .CLEAR_WINS(CLEAR_WINS)) u_chan (
         .clk(clk), .rst_n(rst_n), .run(run_q), .in_phase(in_phase),
         .cnt(cnt_q), .cmp_set(act_set[ch]), .cmp_clr(act_clr[ch]),
         .en(ch_en[ch]), .dflt(ch_dflt[ch]), .pin(pins[ch]), .oe(oes[ch])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc_ovf <= 1'b0;
      else        cyc_ovf <= cyc_end;
   end

   assign pwm_a    = pins[CH_A];
   assign pwm_b    = pins[CH_B];
   assign oe_a     = oes[CH_A];
   assign oe_b     = oes[CH_B];
   assign en_ready = rdy_q;
   assign ramp_b   = ph_b;
endmodule

// File: rtl/pwm2_checker.sv
`timescale 1ns/1ps
module pwm2_checker import pwm2_pkg::*; #(
   parameter int CNT_W = 12
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         run_q,
   input logic                         rdy_q,
   input logic                         two_ramp,
   input logic                         ph_b,
   input logic [CNT_W-1:0]             cnt_q,
   input logic [NUM_CH-1:0][CNT_W-1:0] act_clr,
   input logic                         cyc_ovf,
   input logic                         pwm_a,
   input logic                         pwm_b,
   input logic                         oe_a,
   input logic                         oe_b
);
   a_r8_ready_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_q |=> rdy_q);

   a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(run_q) |-> !rdy_q);

   a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> (cnt_q == '0));

   a_r10_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_ovf |-> (cnt_q == '0));

   a_r1_one_ramp_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && two_ramp == RAMP_ONE) |-> (cnt_q <= act_clr[CH_B]));

   a_r2_first_ramp_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && two_ramp == RAMP_TWO && !ph_b) |-> (cnt_q <= act_clr[CH_A]));

   a_r2_second_ramp_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && ph_b) |-> (cnt_q <= act_clr[CH_B]));

   a_r2_no_phase_in_one: assert property (@(posedge clk) disable iff (!rst_n)
      (two_ramp == RAMP_ONE) |-> !ph_b);

   a_r6_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_a |-> !pwm_a);

   a_r6_quiet_b: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_b |-> !pwm_b);

   a_r9_hold_mid_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $past(run_q) && !cyc_ovf) |-> $stable(act_clr));
endmodule

bind dual_ramp_pwm pwm2_checker #(.CNT_W(CNT_W)) i_pwm2_checker (
   .clk(clk), .rst_n(rst_n), .run_q(run_q), .rdy_q(rdy_q),
   .two_ramp(two_ramp), .ph_b(ph_b), .cnt_q(cnt_q), .act_clr(act_clr),
   .cyc_ovf(cyc_ovf), .pwm_a(pwm_a), .pwm_b(pwm_b), .oe_a(oe_a), .oe_b(oe_b)
);

// File: tb/test_dual_ramp_pwm.sv
`timescale 1ns/1ps
module test_dual_ramp_pwm;
   localparam int CNT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [2:0]       wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic pwm_a, pwm_b, oe_a, oe_b, en_ready, cyc_ovf, ramp_b;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dual_ramp_pwm #(.CNT_W(CNT_W)) i_dual_ramp_pwm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .oe_a(oe_a),
      .oe_b(oe_b), .en_ready(en_ready), .cyc_ovf(cyc_ovf), .ramp_b(ramp_b)
   );

   // style, A-set, A-clear, B-set, B-clear, period, A on-clocks, B on-clocks
   typedef struct packed {
      int m; int as_; int ac; int bs; int bc; int per; int ha; int hb;
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{0,   3,   10,   12,   20,   21,    7,    8},
      '{0,   0,    5,    5,    9,   10,    5,    4},
      '{0,   4,    4,    6,    9,   10,    0,    3},
      '{1,   2,    6,    1,    4,   12,    4,    3},
      '{1,   0,    3,    0,    3,    8,    3,    3},
      '{1,   5,    9,    2,    8,   19,    4,    6},
      '{0, 100, 1124, 2000, 4095, 4096, 1024, 2095}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 3'(a);
      wr_data = CNT_W'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wr_ctrl(input int run, input int mode);
      int g = 0;
      while (!en_ready && g < 10) begin
         @(negedge clk);
         g++;
      end
      wr(4, (mode << 1) | run);
   endtask

   task automatic wait_ovf(output int ok);
      ok = 0;
      for (int g = 0; g < 10000; g++) begin
         @(negedge clk);
         if (cyc_ovf) begin
            ok = 1;
            break;
         end
      end
   endtask

   // called on a falling edge where cyc_ovf is high; window ends before the next strobe
   task automatic measure(output int per, output int ha, output int hb,
                          output int hr, output int ov);
      per = 0; ha = 0; hb = 0; hr = 0; ov = 0;
      do begin
         ha += int'(pwm_a);
         hb += int'(pwm_b);
         hr += int'(ramp_b);
         ov += int'(pwm_a && pwm_b);
         @(negedge clk);
         per++;
      end while (!cyc_ovf && per < 10000);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog (all requirements): actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int ok, per, ha, hb, hr, ov, cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6", "reset oe_a", int'(oe_a), 0);
      chk("R6", "reset pwm_a", int'(pwm_a), 0);
      chk("R8", "reset en_ready", int'(en_ready), 1);
      chk("R10", "reset cyc_ovf", int'(cyc_ovf), 0);
      chk("R2", "reset ramp_b", int'(ramp_b), 0);

      // R7: stopped, enabled outputs show idle levels (A idle 1, B idle 0)
      wr(5, 4'b0111);
      chk("R7", "idle pwm_a", int'(pwm_a), 1);
      chk("R7", "idle pwm_b", int'(pwm_b), 0);
      chk("R6", "oe_a on", int'(oe_a), 1);
      chk("R6", "oe_b on", int'(oe_b), 1);
      cnt = 0;
      repeat (20) begin
         @(negedge clk);
         cnt += int'(cyc_ovf);
      end
      chk("R7", "strobes while stopped", cnt, 0);

      // table walk: R1, R2, R3, R4, R5, R11
      for (int i = 0; i < 7; i++) begin
         wr_ctrl(0, VEC[i].m);
         wr(0, VEC[i].as_);
         wr(1, VEC[i].ac);
         wr(2, VEC[i].bs);
         wr(3, VEC[i].bc);
         wr(5, 4'b0011);
         wr_ctrl(1, VEC[i].m);
         wait_ovf(ok);
         chk("R10", $sformatf("vec%0d strobe seen", i), ok, 1);
         measure(per, ha, hb, hr, ov);
         chk(VEC[i].m == 0 ? "R1" : "R2", $sformatf("vec%0d period", i), per, VEC[i].per);
         chk(VEC[i].ha == 0 ? "R4" : "R3", $sformatf("vec%0d A on-clocks", i), ha, VEC[i].ha);
         chk("R3", $sformatf("vec%0d B on-clocks", i), hb, VEC[i].hb);
         chk("R2", $sformatf("vec%0d second-ramp clocks", i), hr,
             VEC[i].m == 1 ? VEC[i].bc + 1 : 0);
         if (VEC[i].m == 0) chk("R5", $sformatf("vec%0d overlap clocks", i), ov, 0);
      end

      // R8: ready drops for one clock, control write during that clock is ignored
      wr_ctrl(0, 0);
      wr(0, 2); wr(1, 5); wr(2, 7); wr(3, 9);
      wr(5, 4'b0011);
      wr_ctrl(1, 0);
      chk("R8", "ready low after run change", int'(en_ready), 0);
      wr_en   = 1'b1;
      wr_addr = 3'd4;
      wr_data = '0;
      @(negedge clk);
      wr_en   = 1'b0;
      chk("R8", "ready back after one clock", int'(en_ready), 1);
      wait_ovf(ok);
      chk("R8", "stop write while not ready ignored", ok, 1);

      // R9: B-clear rewritten mid-cycle only takes effect on the next cycle
      wait_ovf(ok);
      wr_en   = 1'b1;
      wr_addr = 3'd3;
      wr_data = CNT_W'(15);
      per = 0;
      do begin
         @(negedge clk);
         if (per == 0) wr_en = 1'b0;
         per++;
      end while (!cyc_ovf && per < 10000);
      chk("R9", "cycle in progress keeps old length", per, 10);
      measure(per, ha, hb, hr, ov);
      chk("R9", "next cycle uses new length", per, 16);
      chk("R3", "B on-clocks after reload", hb, 8);

      // R6: channel A disabled while running
      wr(5, 4'b0010);
      chk("R6", "oe_a off", int'(oe_a), 0);
      wait_ovf(ok);
      measure(per, ha, hb, hr, ov);
      chk("R6", "disabled A on-clocks", ha, 0);
      chk("R6", "enabled B on-clocks", hb, 8);

      // R7: stop with A idle 0, B idle 1
      wr(5, 4'b1011);
      wr_ctrl(0, 0);
      chk("R7", "stopped pwm_a idle", int'(pwm_a), 0);
      chk("R7", "stopped pwm_b idle", int'(pwm_b), 1);
      cnt = 0;
      @(negedge clk);
      repeat (20) begin
         @(negedge clk);
         cnt += int'(cyc_ovf) + int'(ramp_b);
      end
      chk("R7", "no strobe after stop", cnt, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule